// File: doc/BRIEF.md
# Two-Way Set-Associative Write-Back Data Cache

This block sits between the memory stage of a pipelined core and a plain word-wide main memory. Every line holds a single 32-bit word. There are two ways per set, and one recency bit per set chooses which way is replaced. The core reads and writes either whole words or single bytes; a three-bit operation code picks between them. On a hit, a load returns its data in the same cycle and a store updates the line in place and marks it dirty.

When an access misses, the block raises its stall output and runs a short refill sequence. If the line being replaced holds modified data, that data is first written back to memory at the address rebuilt from the line's tag and set. The missing word is then requested, and one cycle later it is installed. For a store miss, the store data is merged into the fetched word as it is installed. After the refill the access completes as an ordinary hit.

While the stall output is high, the core must hold its address, data, strobes and operation code steady. With the defaults, the 32-bit address divides into a 22-bit tag, an 8-bit set index and a 2-bit byte offset, giving 256 sets and 2 KB of data.

Top module: `wb2_cache`

## Requirements
- R1: After reset no line is valid, so the first access to any address misses and stalls.
- R2: A load that hits returns the stored word on the read-data output with the stall output low, in the same cycle.
- R3: When the low two bits of the operation code are 00, a load returns the byte in lane 0 to 3 chosen by address bits [1:0], zero-extended to 32 bits. Any other value selects a whole word, and the offset is then ignored.
- R4: A byte store replaces only the addressed byte lane of the cached word and leaves the other three bytes unchanged.
- R5: A miss whose victim is clean or invalid holds the stall output high for exactly three cycles: the detect cycle, the fetch cycle and the install cycle. The access then completes with the stall low.
- R6: A miss whose victim is dirty holds the stall high for four cycles. It performs exactly one memory write of the victim's word, at word address {victim tag, set}, before the fetch.
- R7: The victim of a miss is the way of the set that was not used by the most recent hit or refill in that set.
- R8: A store hit marks the line dirty. A line that was only read or refilled by a load is evicted without any memory write.
- R9: A store miss refills the word from memory, applies the store on top of it, and leaves the line dirty.
- R10: The memory write strobe is asserted only while a dirty victim is written back. With no read or write strobe, the stall output stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| core_addr | input | ADDR_W | Byte address of the access |
| core_wdata | input | 32 | Store data; byte stores use bits [7:0] |
| core_rd | input | 1 | Load strobe |
| core_wr | input | 1 | Store strobe |
| core_funct3 | input | 3 | Operation code; bits [1:0]=00 select byte, other values select word |
| core_rdata | output | 32 | Load data, valid when stall is low |
| core_stall | output | 1 | High while the access is not yet complete |
| mem_addr | output | ADDR_W-2 | Word address to main memory |
| mem_wdata | output | 32 | Write-back data |
| mem_we | output | 1 | Main memory write strobe |
| mem_rdata | input | 32 | Memory read data, registered one cycle after the address |

## Verification
The hardest case to reach from the ports is a dirty victim that is selected by the recency bit rather than by chance. Getting there needs a set where one way was dirtied by a store hit, the other way was touched more recently, and a third tag then misses. The bench walks this exact sequence in every one of the 256 sets: load, byte store, byte load, load of a second tag, store miss on a third tag, and so on. A reference model of tags, dirty bits and recency predicts, for each access, whether it hits, how many stall cycles it takes, and whether a write-back happens. The write-back is then confirmed by reading the evicted word back through a later miss.

// File: rtl/cache_pkg.sv
package cache_pkg;

  localparam int WORD_W = 32;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_WB     = 2'd1,
    ST_FETCH  = 2'd2,
    ST_UPDATE = 2'd3
  } miss_state_t;

  // bits [1:0] of the operation code equal to 00 select a byte access
  function automatic logic op_is_byte(input logic [2:0] op);
    return op[1:0] == 2'b00;
  endfunction

  // read side: pick a lane and zero-extend, or pass the whole word
  function automatic logic [WORD_W-1:0] lane_pick(input logic [WORD_W-1:0] w,
                                                  input logic [1:0] off,
                                                  input logic byte_op);
    logic [WORD_W-1:0] r;
    r = w;
    if (byte_op) r = {24'b0, w[{off, 3'b000} +: 8]};
    return r;
  endfunction

  // write side: overwrite one lane, or replace the whole word
  function automatic logic [WORD_W-1:0] lane_merge(input logic [WORD_W-1:0] old_w,
                                                   input logic [WORD_W-1:0] new_w,
                                                   input logic [1:0] off,
                                                   input logic byte_op);
    logic [WORD_W-1:0] r;
    r = new_w;
    if (byte_op) begin
      r = old_w;
      r[{off, 3'b000} +: 8] = new_w[7:0];
    end
    return r;
  endfunction

endpackage

// File: rtl/cache_tag_store.sv
module cache_tag_store #(
  parameter int SET_BITS = 8,
  parameter int TAG_BITS = 22,
  parameter int DATA_W   = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [SET_BITS-1:0] look_set,
  input  logic [TAG_BITS-1:0] look_tag,
  input  logic                sel_way,
  output logic [1:0]          hit_vec,
  output logic [DATA_W-1:0]   hit_data,
  output logic                lru_bit,
  output logic                sel_valid,
  output logic                sel_dirty,
  output logic [TAG_BITS-1:0] sel_tag,
  output logic [DATA_W-1:0]   sel_data,
  input  logic                wr_en,
  input  logic [SET_BITS-1:0] wr_set,
  input  logic                wr_way,
  input  logic [TAG_BITS-1:0] wr_tag,
  input  logic [DATA_W-1:0]   wr_data,
  input  logic                wr_dirty,
  input  logic                lru_en,
  input  logic [SET_BITS-1:0] lru_set,
  input  logic                lru_val
);
  localparam int SETS = 1 << SET_BITS;
  localparam int WAYS = 2;

  logic [WAYS-1:0][DATA_W-1:0]   way_data;
  logic [WAYS-1:0][TAG_BITS-1:0] way_tag;
  logic [WAYS-1:0]               way_valid;
  logic [WAYS-1:0]               way_dirty;
  logic [SETS-1:0]               lru_q;

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    logic [SETS-1:0]     valid_q;
    logic [SETS-1:0]     dirty_q;
    logic [TAG_BITS-1:0] tag_q  [SETS];
    logic [DATA_W-1:0]   data_q [SETS];
    logic                wsel;

    assign wsel = wr_en && (wr_way == w[0]);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        valid_q <= '0;
        dirty_q <= '0;
      end else if (wsel) begin
        valid_q[wr_set] <= 1'b1;
        dirty_q[wr_set] <= wr_dirty;
      end
    end

    always_ff @(posedge clk) begin
      if (wsel) begin
        tag_q[wr_set]  <= wr_tag;
        data_q[wr_set] <= wr_data;
      end
    end

    assign way_valid[w] = valid_q[look_set];
    assign way_dirty[w] = dirty_q[look_set];
    assign way_tag[w]   = tag_q[look_set];
    assign way_data[w]  = data_q[look_set];
    assign hit_vec[w]   = valid_q[look_set] && (tag_q[look_set] == look_tag);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      lru_q <= '0;
    else if (lru_en) lru_q[lru_set] <= lru_val;
  end

  assign lru_bit   = lru_q[look_set];
  assign hit_data  = hit_vec[1] ? way_data[1] : way_data[0];
  assign sel_valid = way_valid[sel_way];
  assign sel_dirty = way_dirty[sel_way];
  assign sel_tag   = way_tag[sel_way];
  assign sel_data  = way_data[sel_way];

endmodule

// File: rtl/cache_miss_fsm.sv
module cache_miss_fsm
  import cache_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        miss,
  input  logic        victim_dirty,
  output miss_state_t state,
  output logic        stall,
  output logic        in_wb,
  output logic        in_fetch,
  output logic        in_update
);
  miss_state_t nxt;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE:   if (miss) nxt = victim_dirty ? ST_WB : ST_FETCH;
      ST_WB:     nxt = ST_FETCH;
      ST_FETCH:  nxt = ST_UPDATE;
      ST_UPDATE: nxt = ST_IDLE;
      default:   nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= nxt;
  end

  assign in_wb     = state == ST_WB;
  assign in_fetch  = state == ST_FETCH;
  assign in_update = state == ST_UPDATE;
  assign stall     = (state != ST_IDLE) || miss;

  AST_WB_TO_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    in_wb |=> in_fetch); // R6
  AST_FETCH_TO_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
    in_fetch |=> in_update); // R5
  AST_UPDATE_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    in_update |=> (state == ST_IDLE)); // R5
  AST_DIRTY_MISS_TO_WB: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && miss && victim_dirty) |=> in_wb); // R6
  AST_CLEAN_MISS_TO_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && miss && !victim_dirty) |=> in_fetch); // R5

endmodule

// File: rtl/wb2_cache.sv
module wb2_cache
  import cache_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int SET_BITS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] core_addr,
  input  logic [31:0]       core_wdata,
  input  logic              core_rd,
  input  logic              core_wr,
  input  logic [2:0]        core_funct3,
  output logic [31:0]       core_rdata,
  output logic              core_stall,
  output logic [ADDR_W-3:0] mem_addr,
  output logic [31:0]       mem_wdata,
  output logic              mem_we,
  input  logic [31:0]       mem_rdata
);
  localparam int OFF_BITS = 2;
  localparam int TAG_BITS = ADDR_W - SET_BITS - OFF_BITS;

  logic [SET_BITS-1:0] set_c, miss_set_q, look_set, wr_set, lru_set;
  logic [TAG_BITS-1:0] tag_c, miss_tag_q, sel_tag, wr_tag;
  logic [1:0]          off_c, hit_vec;
  logic [31:0]         hit_data, sel_data, wr_data;
  logic                miss_way_q, sel_way, lru_bit, sel_valid, sel_dirty;
  logic                wr_en, wr_way, wr_dirty, lru_en, lru_val;
  logic                is_idle, access, hit_any, hit_evt, miss_evt, byte_op, victim_dirty;
  logic                in_wb, in_fetch, in_update;
  miss_state_t         state;

  assign off_c   = core_addr[OFF_BITS-1:0];
  assign set_c   = core_addr[OFF_BITS +: SET_BITS];
  assign tag_c   = core_addr[ADDR_W-1 -: TAG_BITS];
  assign byte_op = op_is_byte(core_funct3);
  assign is_idle = state == ST_IDLE;
  assign access  = core_rd || core_wr;

  assign look_set = is_idle ? set_c : miss_set_q;
  assign sel_way  = is_idle ? lru_bit : miss_way_q;

  cache_tag_store #(.SET_BITS(SET_BITS), .TAG_BITS(TAG_BITS), .DATA_W(32)) store_i (
    .clk(clk), .rst_n(rst_n),
    .look_set(look_set), .look_tag(tag_c), .sel_way(sel_way),
    .hit_vec(hit_vec), .hit_data(hit_data), .lru_bit(lru_bit),
    .sel_valid(sel_valid), .sel_dirty(sel_dirty), .sel_tag(sel_tag), .sel_data(sel_data),
    .wr_en(wr_en), .wr_set(wr_set), .wr_way(wr_way), .wr_tag(wr_tag),
    .wr_data(wr_data), .wr_dirty(wr_dirty),
    .lru_en(lru_en), .lru_set(lru_set), .lru_val(lru_val)
  );

  assign hit_any      = |hit_vec;
  assign hit_evt      = is_idle && access && hit_any;
  assign miss_evt     = is_idle && access && !hit_any;
  assign victim_dirty = sel_valid && sel_dirty;

  cache_miss_fsm fsm_i (
    .clk(clk), .rst_n(rst_n), .miss(miss_evt), .victim_dirty(victim_dirty),
    .state(state), .stall(core_stall),
    .in_wb(in_wb), .in_fetch(in_fetch), .in_update(in_update)
  );

  // capture the missing line and its victim way at the detect cycle
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      miss_set_q <= '0;
      miss_tag_q <= '0;
      miss_way_q <= 1'b0;
    end else if (miss_evt) begin
      miss_set_q <= set_c;
      miss_tag_q <= tag_c;
      miss_way_q <= lru_bit;
    end
  end

  // one write port: refill install, or store hit
  always_comb begin
    wr_en    = 1'b0;
    wr_set   = set_c;
    wr_way   = hit_vec[1];
    wr_tag   = tag_c;
    wr_data  = lane_merge(hit_data, core_wdata, off_c, byte_op);
    wr_dirty = 1'b1;
    if (in_update) begin
      wr_en    = 1'b1;
      wr_set   = miss_set_q;
      wr_way   = miss_way_q;
      wr_tag   = miss_tag_q;
      wr_data  = core_wr ? lane_merge(mem_rdata, core_wdata, off_c, byte_op) : mem_rdata;
      wr_dirty = core_wr;
    end else if (hit_evt && core_wr) begin
      wr_en = 1'b1;
    end
  end

  // recency: point at the way not just used
  always_comb begin
    lru_en  = 1'b0;
    lru_set = set_c;
    lru_val = ~hit_vec[1];
    if (in_update) begin
      lru_en  = 1'b1;
      lru_set = miss_set_q;
      lru_val = ~miss_way_q;
    end else if (hit_evt) begin
      lru_en = 1'b1;
    end
  end

  assign mem_addr   = in_wb ? {sel_tag, miss_set_q} : {miss_tag_q, miss_set_q};
  assign mem_wdata  = sel_data;
  assign mem_we     = in_wb;
  assign core_rdata = lane_pick(hit_data, off_c, byte_op);

  AST_ONE_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec)); // R7
  AST_HIT_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    hit_evt |-> !core_stall); // R2
  AST_WRITE_ONLY_ON_EVICT: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> $past(victim_dirty)); // R10
  AST_REFILL_THEN_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_update && $stable(core_addr)) |=> (!access || hit_any)); // R9

endmodule

// File: tb/wb2_cache_tb.sv
module wb2_cache_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] core_addr = '0, core_wdata = '0, core_rdata, mem_wdata, mem_rdata;
  logic        core_rd = 1'b0, core_wr = 1'b0, core_stall, mem_we;
  logic [2:0]  core_funct3 = 3'b010;
  logic [29:0] mem_addr;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wb2_cache dut_i (
    .clk(clk), .rst_n(rst_n), .core_addr(core_addr), .core_wdata(core_wdata),
    .core_rd(core_rd), .core_wr(core_wr), .core_funct3(core_funct3),
    .core_rdata(core_rdata), .core_stall(core_stall),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_rdata(mem_rdata)
  );

  // main memory: 4096 words, registered read
  logic [31:0] mem    [4096];
  logic [31:0] golden [4096];
  logic [31:0] rd_q;
  int          wb_count = 0;
  logic [11:0] wb_last  = '0;

  always @(posedge clk) begin
    if (mem_we) begin
      mem[mem_addr[11:0]] <= mem_wdata;
      wb_count <= wb_count + 1;
      wb_last  <= mem_addr[11:0];
    end
    rd_q <= mem[mem_addr[11:0]];
  end
  assign mem_rdata = rd_q;

  // reference of cache contents
  logic [21:0] m_tag   [256][2];
  logic        m_val   [256][2];
  logic        m_dirty [256][2];
  logic        m_lru   [256];

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [11:0] gidx(input logic [21:0] tag, input logic [7:0] set);
    return {tag[3:0], set};
  endfunction

  task automatic access(input logic [21:0] tag, input logic [7:0] set, input logic [1:0] off,
                        input bit wr, input bit byte_op, input logic [31:0] wd, input string req);
    int          stalls, exp_stalls, wb_before;
    bit          hit, vic_dirty;
    int          way;
    logic [11:0] gi, vi;
    logic [31:0] exp_d, rdata;
    hit = 0; way = m_lru[set];
    for (int w = 0; w < 2; w++)
      if (m_val[set][w] && m_tag[set][w] == tag) begin hit = 1; way = w; end
    vic_dirty  = !hit && m_val[set][way] && m_dirty[set][way];
    vi         = gidx(m_tag[set][way], set);
    exp_stalls = hit ? 0 : (vic_dirty ? 4 : 3);
    gi         = gidx(tag, set);
    wb_before  = wb_count;

    @(negedge clk);
    core_addr   = {tag, set, off};
    core_wdata  = wd;
    core_rd     = !wr;
    core_wr     = wr;
    core_funct3 = byte_op ? (wr ? 3'b000 : 3'b100) : 3'b010;
    stalls = 0;
    #1;
    while (core_stall && stalls < 20) begin
      stalls++;
      @(negedge clk);
      #1;
    end
    rdata = core_rdata;
    @(negedge clk);
    core_rd = 1'b0;
    core_wr = 1'b0;

    check(stalls == exp_stalls, req, stalls, exp_stalls);
    if (!wr) begin
      exp_d = byte_op ? {24'b0, golden[gi][off*8 +: 8]} : golden[gi];
      check(rdata == exp_d, req, rdata, exp_d);
    end
    if (vic_dirty) begin
      check(wb_count == wb_before + 1, "R8", wb_count, wb_before + 1);
      check(wb_last == vi, "R6", {20'b0, wb_last}, {20'b0, vi});
      check(mem[vi] == golden[vi], "R6", mem[vi], golden[vi]);
    end else begin
      check(wb_count == wb_before, "R10", wb_count, wb_before);
    end

    if (wr) begin
      if (byte_op) golden[gi][off*8 +: 8] = wd[7:0];
      else         golden[gi] = wd;
    end
    m_val[set][way] = 1'b1;
    m_tag[set][way] = tag;
    m_dirty[set][way] = hit ? (m_dirty[set][way] | wr) : wr;
    m_lru[set] = (way == 0);
  endtask

  initial begin
    for (int i = 0; i < 4096; i++) begin
      mem[i]    = i * 32'h9E3779B1 + 32'h01234567;
      golden[i] = i * 32'h9E3779B1 + 32'h01234567;
    end
    for (int s = 0; s < 256; s++) begin
      m_lru[s] = 1'b0;
      for (int w = 0; w < 2; w++) begin
        m_val[s][w] = 1'b0; m_dirty[s][w] = 1'b0; m_tag[s][w] = '0;
      end
    end
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    #1;
    check(core_stall == 1'b0, "R10", core_stall, 0);
    check(mem_we == 1'b0, "R10", mem_we, 0);

    for (int s = 0; s < 256; s++) begin
      logic [7:0]  set;
      logic [1:0]  off;
      logic [17:0] hi;
      set = s[7:0];
      off = s[1:0];
      hi  = s[17:0];
      access({hi, 4'd0}, set, 2'd0, 0, 0, 32'h0, "R1");
      access({hi, 4'd0}, set, off, 1, 1, {24'h0, set ^ 8'h5A}, "R4");
      access({hi, 4'd0}, set, off, 0, 1, 32'h0, "R3");
      access({hi, 4'd0}, set, 2'd0, 0, 0, 32'h0, "R4");
      access({hi, 4'd1}, set, off + 2'd1, 0, 1, 32'h0, "R5");
      access({hi, 4'd2}, set, 2'd0, 1, 0, {set, 24'hC0FFEE}, "R9");
      access({hi, 4'd1}, set, 2'd0, 0, 0, 32'h0, "R7");
      access({hi, 4'd2}, set, 2'd0, 0, 0, 32'h0, "R9");
      access({hi, 4'd0}, set, 2'd0, 0, 0, 32'h0, "R6");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule